// File: doc/BRIEF.md
# Ping-Pong Conversion Sequence Controller

This block schedules the sample and conversion slots of a multi-slot analog-to-digital converter. There are `NUM_SLOTS` slots, split into a lower half and an upper half. Software seeds activity by force-starting a set of slots. After that, two interrupt lines keep the sequence running by themselves. The end of conversion of a chosen slot raises a pulse on line 1, and that pulse requests every slot of the upper half. The end of conversion of another chosen slot raises a pulse on line 2, and that pulse requests every slot of the lower half. With sources 6 and 14 and the default of 16 slots, the two halves alternate without end.

A single sampler state machine serves pending slots. It has three states:
- `S_IDLE`: waits for a pending slot and for permission to sample.
- `S_SAMPLE`: runs the acquisition window of the chosen slot.
- `S_HOLD`: the window is over but the converter is still busy.

The transitions are:
- `S_IDLE` → `S_SAMPLE` on take.
- `S_SAMPLE` → `S_IDLE` when the window ends and the conversion is issued.
- `S_SAMPLE` → `S_HOLD` when the window ends but the converter is not free.
- `S_HOLD` → `S_IDLE` when the conversion is issued.

The converter core sits outside the block. The block issues a one-cycle `conv_start` together with the slot number. The core answers with a one-cycle `conv_done` a fixed `CONV_CYCLES` clocks later.

An overlap mode lets the next sample window begin while the current conversion still has up to `OVERLAP_CLKS` clocks to run. A non-overlap control makes sampling wait until the conversion has finished.

Each line has its own enable, continuous-mode control, flag and flag clear. A line that is not in continuous mode issues no new pulse while its flag is still set. Leaving such a flag uncleared therefore halts the chain.

Top module: `pingpong_seq_ctrl`

## Requirements
- R1: After reset, `sampling`, `conv_start`, `int_pulse` and `int_flag` are all 0, and no slot is pending.
- R2: When `force_go` is high, every slot whose bit is set in `force_mask` becomes pending. Pending slots are served one at a time, lowest index first. `conv_start` is issued only when the converter is idle or reports `conv_done` in that same cycle.
- R3: A request for a slot that is already pending is merged with the existing request. It produces no second conversion.
- R4: The acquisition setting of slot k sits at `acq_win[k*ACQ_W +: ACQ_W]`. The sample window of slot k keeps `sampling` high for that value plus one clock. `conv_start` is asserted in the last cycle of the window when the converter is free.
- R5: With `no_overlap`=1, sampling begins only in the cycle after `conv_done`. Consecutive `conv_start`s are therefore CONV_CYCLES+1+acq clocks apart, where acq is the setting of the later slot.
- R6: With `no_overlap`=0, sampling may begin once `OVERLAP_CLKS` or fewer clocks of the current conversion remain. The next `conv_start` comes at the later of the end of the window and the completion of the conversion. For back-to-back slots the spacing is max(CONV_CYCLES+2-OVERLAP_CLKS+acq, CONV_CYCLES).
- R7: Index 0 of `int_en`, `int_cont`, `flag_clr`, `int_pulse` and `int_flag` is line 1, and index 1 is line 2. When an enabled line sees `conv_done` for the slot selected by its source input, it sets its flag. Its pulse, when issued, comes exactly one clock after that `conv_done`.
- R8: A pulse on line 1 makes all upper-half slots pending, and a pulse on line 2 makes all lower-half slots pending. With sources 6 and 14 in continuous mode, a force of the lower half gives conversions in slot order 0 to 15, repeating.
- R9: A line with continuous mode off issues no pulse while its flag is set, so the chain halts.
- R10: Asserting `flag_clr` for a line clears that line's flag.
- R11: A disabled line issues no pulse and sets no flag. With both lines disabled, the sequence stops once the pending slots are done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| force_go | input | 1 | Software force-start strobe |
| force_mask | input | NUM_SLOTS | Slots made pending by the force-start |
| int_en | input | 2 | Line enables (bit 0 = line 1) |
| int_cont | input | 2 | Continuous-mode controls per line |
| int1_src | input | SLOT_W | End-of-conversion slot that drives line 1 |
| int2_src | input | SLOT_W | End-of-conversion slot that drives line 2 |
| flag_clr | input | 2 | Flag clear strobes per line |
| acq_win | input | NUM_SLOTS*ACQ_W | Per-slot acquisition settings (window = value + 1) |
| no_overlap | input | 1 | 1: sampling waits for conversion completion |
| conv_start | output | 1 | One-cycle conversion request to the core |
| conv_slot | output | SLOT_W | Slot number of the request |
| conv_done | input | 1 | One-cycle completion from the core |
| sampling | output | 1 | High during the acquisition window |
| int_pulse | output | 2 | Interrupt pulses per line |
| int_flag | output | 2 | Interrupt flags per line |

## Verification
The bench builds the block with its defaults: 16 slots, 6-bit acquisition settings, a 13-clock conversion and a 7-clock overlap limit. It models the core with the same 13-clock delay. With these values the half boundary at slot 8 and the sources 6 and 14 give a visible alternating 0 to 15 order. A non-continuous line halts the chain after exactly 24 conversions. In overlap mode, a zero acquisition setting ends its window before the conversion completes (8 < 13), which drives the sampler into `S_HOLD`. A setting of 6 ends the window one clock after completion, so both branches of R6 are reachable.

// File: rtl/pp_seq_pkg.sv
package pp_seq_pkg;

    typedef enum logic [1:0] {
        S_IDLE   = 2'd0,
        S_SAMPLE = 2'd1,
        S_HOLD   = 2'd2
    } samp_state_e;

    localparam int LINE_UP_TRIG = 0;   // line 1 requests the upper half
    localparam int LINE_LO_TRIG = 1;   // line 2 requests the lower half

endpackage

// File: rtl/pp_slot_pending.sv
module pp_slot_pending #(
    parameter int NUM_SLOTS = 16,
    parameter int SLOT_W    = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_SLOTS-1:0] set_mask,
    input  logic                 take,
    input  logic [SLOT_W-1:0]    take_slot,
    output logic                 pend_any,
    output logic [SLOT_W-1:0]    pick_slot
);

    logic [NUM_SLOTS-1:0] pending;
    logic [NUM_SLOTS-1:0] clr_mask;

    always_comb begin
        clr_mask = '0;
        if (take) clr_mask[take_slot] = 1'b1;
    end

    // Requests merge into the bitmap: a slot already pending stays one entry.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pending <= '0;
        else        pending <= (pending & ~clr_mask) | set_mask;
    end

    // Lowest index wins: scan downward so the last hit is the smallest.
    always_comb begin
        pick_slot = '0;
        for (int i = NUM_SLOTS - 1; i >= 0; i--) begin
            if (pending[i]) pick_slot = SLOT_W'(i);
        end
    end

    assign pend_any = |pending;

endmodule

// File: rtl/pp_conv_tracker.sv
module pp_conv_tracker #(
    parameter int SLOT_W      = 4,
    parameter int CONV_CYCLES = 13,
    parameter int CNT_W       = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              conv_start,
    input  logic [SLOT_W-1:0] conv_slot,
    input  logic              conv_done,
    output logic              busy,
    output logic [CNT_W-1:0]  remain,
    output logic              eoc_valid,
    output logic [SLOT_W-1:0] eoc_slot
);

    logic [SLOT_W-1:0] slot_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy   <= 1'b0;
            remain <= '0;
            slot_q <= '0;
        end else if (conv_start) begin
            busy   <= 1'b1;
            remain <= CNT_W'(CONV_CYCLES);
            slot_q <= conv_slot;
        end else if (conv_done) begin
            busy   <= 1'b0;
            remain <= '0;
        end else if (busy && remain != '0) begin
            remain <= remain - 1'b1;
        end
    end

    // A completion always belongs to the conversion in flight.
    assign eoc_valid = conv_done && busy;
    assign eoc_slot  = slot_q;

endmodule

// File: rtl/pp_int_line.sv
module pp_int_line #(
    parameter int SLOT_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              cont,
    input  logic [SLOT_W-1:0] src,
    input  logic              clr,
    input  logic              eoc_valid,
    input  logic [SLOT_W-1:0] eoc_slot,
    output logic              pulse,
    output logic              flag
);

    logic hit;

    assign hit = en && eoc_valid && (eoc_slot == src);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pulse <= 1'b0;
            flag  <= 1'b0;
        end else begin
            pulse <= hit && (cont || !flag);
            if (hit)      flag <= 1'b1;
            else if (clr) flag <= 1'b0;
        end
    end

endmodule

// File: rtl/pingpong_seq_ctrl.sv
module pingpong_seq_ctrl
    import pp_seq_pkg::*;
#(
    parameter int NUM_SLOTS    = 16,
    parameter int ACQ_W        = 6,
    parameter int CONV_CYCLES  = 13,
    parameter int OVERLAP_CLKS = 7,
    parameter int SLOT_W       = $clog2(NUM_SLOTS)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       force_go,
    input  logic [NUM_SLOTS-1:0]       force_mask,
    input  logic [1:0]                 int_en,
    input  logic [1:0]                 int_cont,
    input  logic [SLOT_W-1:0]          int1_src,
    input  logic [SLOT_W-1:0]          int2_src,
    input  logic [1:0]                 flag_clr,
    input  logic [NUM_SLOTS*ACQ_W-1:0] acq_win,
    input  logic                       no_overlap,
    output logic                       conv_start,
    output logic [SLOT_W-1:0]          conv_slot,
    input  logic                       conv_done,
    output logic                       sampling,
    output logic [1:0]                 int_pulse,
    output logic [1:0]                 int_flag
);

    localparam int HALF  = NUM_SLOTS / 2;
    localparam int CNT_W = $clog2(CONV_CYCLES + 1);
    localparam logic [NUM_SLOTS-1:0] LO_MASK = {{(NUM_SLOTS - HALF){1'b0}}, {HALF{1'b1}}};
    localparam logic [NUM_SLOTS-1:0] HI_MASK = ~LO_MASK;

    samp_state_e        state, state_nx;
    logic [ACQ_W-1:0]   acq_cnt;
    logic [SLOT_W-1:0]  cur_slot;
    logic [ACQ_W-1:0]   acq_arr [NUM_SLOTS];
    logic [NUM_SLOTS-1:0] set_mask;
    logic               take;
    logic               pend_any;
    logic [SLOT_W-1:0]  pick_slot;
    logic               trk_busy;
    logic [CNT_W-1:0]   trk_remain;
    logic               eoc_valid;
    logic [SLOT_W-1:0]  eoc_slot;
    logic               conv_free;
    logic               may_sample;
    logic [SLOT_W-1:0]  line_src [2];

    for (genvar k = 0; k < NUM_SLOTS; k++) begin : g_acq
        assign acq_arr[k] = acq_win[k*ACQ_W +: ACQ_W];
    end

    assign line_src[LINE_UP_TRIG] = int1_src;
    assign line_src[LINE_LO_TRIG] = int2_src;

    // Force-start and cross-triggers feed the pending bitmap.
    assign set_mask = (force_go ? force_mask : '0)
                    | (int_pulse[LINE_UP_TRIG] ? HI_MASK : '0)
                    | (int_pulse[LINE_LO_TRIG] ? LO_MASK : '0);

    pp_slot_pending #(.NUM_SLOTS(NUM_SLOTS), .SLOT_W(SLOT_W)) u_pend (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_mask  (set_mask),
        .take      (take),
        .take_slot (pick_slot),
        .pend_any  (pend_any),
        .pick_slot (pick_slot)
    );

    pp_conv_tracker #(.SLOT_W(SLOT_W), .CONV_CYCLES(CONV_CYCLES), .CNT_W(CNT_W)) u_trk (
        .clk        (clk),
        .rst_n      (rst_n),
        .conv_start (conv_start),
        .conv_slot  (conv_slot),
        .conv_done  (conv_done),
        .busy       (trk_busy),
        .remain     (trk_remain),
        .eoc_valid  (eoc_valid),
        .eoc_slot   (eoc_slot)
    );

    for (genvar g = 0; g < 2; g++) begin : g_line
        pp_int_line #(.SLOT_W(SLOT_W)) u_line (
            .clk       (clk),
            .rst_n     (rst_n),
            .en        (int_en[g]),
            .cont      (int_cont[g]),
            .src       (line_src[g]),
            .clr       (flag_clr[g]),
            .eoc_valid (eoc_valid),
            .eoc_slot  (eoc_slot),
            .pulse     (int_pulse[g]),
            .flag      (int_flag[g])
        );
    end

    assign conv_free  = !trk_busy || conv_done;
    assign may_sample = conv_free || (!no_overlap && trk_remain <= CNT_W'(OVERLAP_CLKS));

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    // Next state
    always_comb begin
        state_nx = state;
        take     = 1'b0;
        unique case (state)
            S_IDLE: begin
                if (pend_any && may_sample) begin
                    take     = 1'b1;
                    state_nx = S_SAMPLE;
                end
            end
            S_SAMPLE: begin
                if (acq_cnt == '0) state_nx = conv_free ? S_IDLE : S_HOLD;
            end
            S_HOLD: begin
                if (conv_free) state_nx = S_IDLE;
            end
            default: state_nx = S_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        sampling   = (state == S_SAMPLE);
        conv_slot  = cur_slot;
        conv_start = 1'b0;
        unique case (state)
            S_SAMPLE: conv_start = (acq_cnt == '0) && conv_free;
            S_HOLD:   conv_start = conv_free;
            default:  conv_start = 1'b0;
        endcase
    end

    // Window counter and slot register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acq_cnt  <= '0;
            cur_slot <= '0;
        end else if (take) begin
            acq_cnt  <= acq_arr[pick_slot];
            cur_slot <= pick_slot;
        end else if (state == S_SAMPLE && acq_cnt != '0) begin
            acq_cnt <= acq_cnt - 1'b1;
        end
    end

endmodule

// File: rtl/pingpong_seq_ctrl_chk.sv
module pingpong_seq_ctrl_chk #(
    parameter int SLOT_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              no_overlap,
    input logic              sampling,
    input logic              conv_start,
    input logic              conv_done,
    input logic              trk_busy,
    input logic              eoc_valid,
    input logic [SLOT_W-1:0] eoc_slot,
    input logic [SLOT_W-1:0] int1_src,
    input logic [SLOT_W-1:0] int2_src,
    input logic [1:0]        int_en,
    input logic [1:0]        int_cont,
    input logic [1:0]        flag_clr,
    input logic [1:0]        int_pulse,
    input logic [1:0]        int_flag
);

    assert_start_free_R2: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |-> (!trk_busy || conv_done));

    assert_no_overlap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (no_overlap && sampling) |-> !trk_busy);

    assert_line1_src_R7: assert property (@(posedge clk) disable iff (!rst_n)
        int_pulse[0] |-> $past(eoc_valid && eoc_slot == int1_src));

    assert_line2_src_R7: assert property (@(posedge clk) disable iff (!rst_n)
        int_pulse[1] |-> $past(eoc_valid && eoc_slot == int2_src));

    assert_flag_block_R9: assert property (@(posedge clk) disable iff (!rst_n)
        int_pulse[0] |-> ($past(int_cont[0]) || !$past(int_flag[0])));

    assert_flag_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(int_flag[0]) |-> $past(flag_clr[0]));

    assert_line_enable_R11: assert property (@(posedge clk) disable iff (!rst_n)
        int_pulse[1] |-> $past(int_en[1]));

endmodule

bind pingpong_seq_ctrl pingpong_seq_ctrl_chk #(.SLOT_W(SLOT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .no_overlap (no_overlap),
    .sampling   (sampling),
    .conv_start (conv_start),
    .conv_done  (conv_done),
    .trk_busy   (trk_busy),
    .eoc_valid  (eoc_valid),
    .eoc_slot   (eoc_slot),
    .int1_src   (int1_src),
    .int2_src   (int2_src),
    .int_en     (int_en),
    .int_cont   (int_cont),
    .flag_clr   (flag_clr),
    .int_pulse  (int_pulse),
    .int_flag   (int_flag)
);

// File: tb/pingpong_seq_ctrl_bench.sv
module pingpong_seq_ctrl_bench;

    localparam int NS   = 16;
    localparam int AW   = 6;
    localparam int SW   = 4;
    localparam int CONV = 13;
    localparam int OVL  = 7;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           force_go = 1'b0;
    logic [NS-1:0]  force_mask = '0;
    logic [1:0]     int_en = 2'b00;
    logic [1:0]     int_cont = 2'b00;
    logic [SW-1:0]  int1_src = 4'd6;
    logic [SW-1:0]  int2_src = 4'd14;
    logic [1:0]     flag_clr = 2'b00;
    logic [NS*AW-1:0] acq_win = '0;
    logic           no_overlap = 1'b1;
    logic           conv_start;
    logic [SW-1:0]  conv_slot;
    logic           conv_done;
    logic           sampling;
    logic [1:0]     int_pulse;
    logic [1:0]     int_flag;

    pingpong_seq_ctrl u_pingpong_seq_ctrl (
        .clk(clk), .rst_n(rst_n), .force_go(force_go), .force_mask(force_mask),
        .int_en(int_en), .int_cont(int_cont), .int1_src(int1_src), .int2_src(int2_src),
        .flag_clr(flag_clr), .acq_win(acq_win), .no_overlap(no_overlap),
        .conv_start(conv_start), .conv_slot(conv_slot), .conv_done(conv_done),
        .sampling(sampling), .int_pulse(int_pulse), .int_flag(int_flag)
    );

    always #5 clk = ~clk;

    // Converter core model: done exactly CONV clocks after the start cycle.
    logic       core_busy = 1'b0;
    logic [4:0] core_cnt = '0;
    always @(posedge clk) begin
        if (!rst_n) begin
            core_busy <= 1'b0;
            core_cnt  <= '0;
        end else if (conv_start) begin
            core_busy <= 1'b1;
            core_cnt  <= 5'(CONV - 1);
        end else if (core_busy && core_cnt == 0) begin
            core_busy <= 1'b0;
        end else if (core_busy) begin
            core_cnt <= core_cnt - 1'b1;
        end
    end
    assign conv_done = core_busy && core_cnt == 0;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    // Monitor, sampled on the falling edge
    int st_slot [64];
    int st_cyc  [64];
    int runs    [64];
    int log_n = 0, run_n = 0, run = 0;
    int p1_n = 0, p2_n = 0, p1_first = -1;
    always @(negedge clk) begin
        if (conv_start && log_n < 64) begin
            st_slot[log_n] = int'(conv_slot);
            st_cyc[log_n]  = cyc;
            log_n++;
        end
        if (sampling) run++;
        else if (run > 0) begin
            if (run_n < 64) runs[run_n] = run;
            run_n++;
            run = 0;
        end
        if (int_pulse[0]) begin
            p1_n++;
            if (p1_first < 0) p1_first = cyc;
        end
        if (int_pulse[1]) p2_n++;
    end

    int n_chk = 0, n_fail = 0;

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic clear_log();
        log_n = 0; run_n = 0; run = 0;
        p1_n = 0; p2_n = 0; p1_first = -1;
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic force_slots(input logic [NS-1:0] m);
        @(posedge clk); #1;
        force_go = 1'b1; force_mask = m;
        @(posedge clk); #1;
        force_go = 1'b0; force_mask = '0;
    endtask

    task automatic pulse_clr(input logic [1:0] c);
        @(posedge clk); #1;
        flag_clr = c;
        @(posedge clk); #1;
        flag_clr = 2'b00;
    endtask

    task automatic t_reset();
        @(negedge clk);
        check("R1 sampling", int'(sampling), 0);
        check("R1 conv_start", int'(conv_start), 0);
        check("R1 int_pulse", int'(int_pulse), 0);
        check("R1 int_flag", int'(int_flag), 0);
        idle(20);
        check("R1 no pending work", log_n, 0);
    endtask

    task automatic t_force_order();
        int_en = 2'b00;
        clear_log();
        force_slots(16'h00FF);
        idle(400);
        check("R2 R11 conversions with lines off", log_n, 8);
        for (int i = 0; i < 8; i++) check("R2 ascending order", st_slot[i], i);
        check("R11 flags stay clear", int'(int_flag), 0);
        check("R11 no pulses", p1_n + p2_n, 0);
    endtask

    task automatic t_merge();
        clear_log();
        force_slots(16'h0006);
        @(posedge clk); #1;
        force_go = 1'b1; force_mask = 16'h0004;
        @(posedge clk); #1;
        force_go = 1'b0; force_mask = '0;
        idle(200);
        check("R3 merged request count", log_n, 2);
        check("R3 first slot", st_slot[0], 1);
        check("R3 second slot", st_slot[1], 2);
    endtask

    task automatic t_window_nonoverlap();
        no_overlap = 1'b1;
        acq_win[1*AW +: AW] = 6'd6;
        acq_win[2*AW +: AW] = 6'd2;
        acq_win[3*AW +: AW] = 6'd0;
        clear_log();
        force_slots(16'h000E);
        idle(200);
        check("R4 window slot1", runs[0], 7);
        check("R4 window slot2", runs[1], 3);
        check("R4 window slot3", runs[2], 1);
        check("R5 spacing acq2", st_cyc[1] - st_cyc[0], CONV + 1 + 2);
        check("R5 spacing acq0", st_cyc[2] - st_cyc[1], CONV + 1 + 0);
    endtask

    task automatic t_window_overlap();
        no_overlap = 1'b0;
        acq_win[2*AW +: AW] = 6'd6;
        acq_win[3*AW +: AW] = 6'd0;
        clear_log();
        force_slots(16'h000E);
        idle(200);
        check("R6 spacing acq6", st_cyc[1] - st_cyc[0], CONV + 2 - OVL + 6);
        check("R6 spacing acq0 waits for core", st_cyc[2] - st_cyc[1], CONV);
        check("R4 window under overlap", runs[1], 7);
        no_overlap = 1'b1;
        for (int k = 0; k < NS; k++) acq_win[k*AW +: AW] = 6'd6;
    endtask

    task automatic t_pingpong();
        int n_stop;
        pulse_clr(2'b11);
        int_en = 2'b11; int_cont = 2'b11;
        clear_log();
        force_slots(16'h00FF);
        for (int w = 0; w < 3000 && log_n < 40; w++) idle(1);
        int_en = 2'b00;
        check("R8 reached 40 conversions", int'(log_n >= 40), 1);
        for (int i = 0; i < 40; i++) check("R8 alternating order", st_slot[i], i % 16);
        idle(600);
        n_stop = log_n;
        idle(200);
        check("R11 chain stopped", log_n, n_stop);
    endtask

    task automatic t_noncont();
        pulse_clr(2'b11);
        check("R10 both flags cleared", int'(int_flag), 0);
        int_en = 2'b11; int_cont = 2'b00;
        clear_log();
        force_slots(16'h00FF);
        idle(1200);
        check("R9 halted after three groups", log_n, 24);
        check("R9 last slot", st_slot[23], 7);
        check("R9 line1 pulse count", p1_n, 1);
        check("R9 line2 pulse count", p2_n, 1);
        check("R7 flags set", int'(int_flag), 3);
        check("R7 pulse one clock after done of slot 6", p1_first - st_cyc[6], CONV + 1);
        pulse_clr(2'b01);
        check("R10 line1 flag cleared", int'(int_flag), 2);
        int_en = 2'b00;
        pulse_clr(2'b11);
    endtask

    initial begin
        for (int k = 0; k < NS; k++) acq_win[k*AW +: AW] = 6'd6;
        idle(4);
        rst_n = 1'b1;
        t_reset();
        t_force_order();
        t_merge();
        t_window_nonoverlap();
        t_window_overlap();
        t_pingpong();
        t_noncont();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(200000 * 10);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

endmodule